// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block is the device half of a receive path built around a small ring of receive descriptors held in local storage. Host software prepares each entry with a buffer address and a capacity, then hands it to the device by setting its ownership bit. Frames arrive as a byte stream with start and end markers. On each frame start the engine looks at the descriptor under its ring index. If the device owns that entry, it streams the bytes into the referenced buffer. At the end of the frame it replaces the status word with the byte count and error summary, returns ownership to the host and steps to the next entry.

Each descriptor has four 32-bit words: status, tag, buffer address low and buffer address high. Word 0 is the status. Its bit 31 is ownership (1 = device), bit 30 marks the last ring entry, and bits 12:0 hold the buffer capacity while armed and the received length after write-back. The host reaches every word through a simple indexed read/write port. A frame that finds a host-owned entry is discarded and counted. A frame longer than the smaller of the buffer capacity and the configured maximum length is cut short and flagged.

Top module: `rxr_ring_wb`

## Requirements
- R1: After reset the ring index is 0, the interrupt status is 0, the missed-frame count is 0 and no buffer write is issued.
- R2: When the current descriptor has bit 31 set at frame start, byte k of the frame is written to address (buffer-low word + k) in the same cycle it appears on the input, in arrival order, with idle input cycles producing no write.
- R3: At frame end the status word is rewritten with bit 31 cleared, bit 30 kept as armed, and bits 12:0 holding the number of bytes stored, the trailing 4 CRC bytes included. All bits not named in R3 to R6 are written 0.
- R4: A frame whose last byte carries the CRC-error input gets status bit 19 and the error summary bit 21 set.
- R5: A frame of fewer than MIN_FRAME (default 64) bytes gets the runt bit 20 and bit 21 set.
- R6: The limit is the smaller of status bits 12:0 at frame start and cfg_max_len. Bytes at positions at or beyond the limit are not written, the length field equals the limit, and bits 22 and 21 are set.
- R7: After each write-back the index advances by one. It returns to 0 after an entry whose bit 30 is set, or after entry DEPTH-1.
- R8: A frame starting while the current descriptor has bit 31 clear produces no buffer write and leaves that descriptor and the index unchanged. The missed-frame count rises by one.
- R9: Each write-back sets interrupt status bit 0 if bit 21 of the written status is 0 and bit 1 otherwise. The bits hold until cleared by a 1 on the matching irq_clr bit; a set in the same cycle takes priority over the clear.
- R10: The host port writes the word selected by host_idx and host_word (0 status, 1 tag, 2 buffer low, 3 buffer high) on a clock edge with host_we, and host_rdata shows that word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_crc_err | input | 1 | CRC failure, sampled with the last byte |
| cfg_max_len | input | 16 | Largest accepted frame length in bytes |
| host_we | input | 1 | Host descriptor write strobe |
| host_idx | input | $clog2(DEPTH) | Host descriptor select |
| host_word | input | 2 | Host word select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected descriptor word |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| cur_idx | output | $clog2(DEPTH) | Current ring index |
| missed_cnt | output | CNT_W | Frames dropped for lack of a device-owned descriptor |
| irq_status | output | 2 | Bit 0 clean write-back, bit 1 errored write-back |
| irq_clr | input | 2 | Write-one-to-clear for irq_status |

## Verification
The hardest state to reach is a frame arriving at an entry the host has not re-armed. Only the ring wrapping back onto an entry already written back by the device produces it. The stimulus gets there by walking all four entries to the end-of-ring wrap, then sending a frame without re-arming entry 0. In the random phase it also skips re-arming about one frame in six. Truncation is driven from both sides, once with cfg_max_len as the tighter limit and once with the descriptor capacity as the tighter limit.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int OWN_BIT  = 31;
   localparam int EOR_BIT  = 30;
   localparam int OVS_BIT  = 22;
   localparam int ERR_BIT  = 21;
   localparam int RUNT_BIT = 20;
   localparam int CRC_BIT  = 19;
   localparam int LEN_W    = 13;
   localparam int MAXL_W   = 16;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_STORE = 2'd1,
      FS_DROP  = 2'd2
   } fstate_e;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
   parameter int DEPTH = 4,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [IW-1:0] host_idx,
   input  logic [1:0]    host_word,
   input  logic [31:0]   host_wdata,
   output logic [31:0]   host_rdata,
   input  logic [IW-1:0] hw_idx,
   output logic [31:0]   hw_status,
   output logic [31:0]   hw_buf_lo,
   input  logic          wb_en,
   input  logic [31:0]   wb_status
);
   logic [31:0] words_q [DEPTH][4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++)
            for (int w = 0; w < 4; w++)
               words_q[e][w] <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (host_we && host_idx == IW'(e))
               words_q[e][host_word] <= host_wdata;
            // device write-back wins over a host write to the same status word
            if (wb_en && hw_idx == IW'(e))
               words_q[e][0] <= wb_status;
         end
      end
   end

   assign host_rdata = words_q[host_idx][host_word];
   assign hw_status  = words_q[hw_idx][0];
   assign hw_buf_lo  = words_q[hw_idx][2];
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int DEPTH = 4,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          eor,
   output logic [IW-1:0] idx
);
   logic [IW-1:0] step;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign step = idx + 1'b1;
      end else begin : g_cmp
         assign step = (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= eor ? '0 : step;
   end
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
   import rxr_pkg::*;
#(
   parameter int MIN_FRAME = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [7:0]        in_data,
   input  logic              in_crc_err,
   input  logic [MAXL_W-1:0] cfg_max_len,
   input  logic [31:0]       d_status,
   input  logic [31:0]       d_buf_lo,
   output logic              buf_we,
   output logic [31:0]       buf_addr,
   output logic [7:0]        buf_data,
   output logic              wb_en,
   output logic [31:0]       wb_status,
   output logic              wb_eor,
   output logic              miss_inc
);
   localparam int CW = MAXL_W;

   fstate_e          st_q, st_d;
   logic [CW-1:0]    cnt_q, cnt_eff, cnt_nx;
   logic [CW-1:0]    lim_q, lim_new, lim_eff, cap;
   logic [31:0]      base_q, base_eff;
   logic             ovf_q, ovf_eff, eor_q;
   logic             start, take, skip, in_frame, fits, runt;
   logic [CW:0]      rcv;
   logic [LEN_W-1:0] stored;

   assign start    = in_valid && in_sof && (st_q == FS_IDLE);
   assign take     = start && d_status[OWN_BIT];
   assign skip     = start && !d_status[OWN_BIT];
   assign in_frame = take || ((st_q == FS_STORE) && in_valid);

   assign cap      = CW'(d_status[LEN_W-1:0]);
   assign lim_new  = (cap < cfg_max_len) ? cap : cfg_max_len;
   assign lim_eff  = take ? lim_new : lim_q;
   assign base_eff = take ? d_buf_lo : base_q;
   assign cnt_eff  = take ? '0 : cnt_q;
   assign cnt_nx   = (cnt_eff == '1) ? cnt_eff : cnt_eff + 1'b1;
   assign fits     = cnt_eff < lim_eff;
   assign ovf_eff  = (take ? 1'b0 : ovf_q) || (in_frame && !fits);

   assign buf_we   = in_frame && fits;
   assign buf_addr = base_eff + 32'(cnt_eff);
   assign buf_data = in_data;

   assign rcv      = {1'b0, cnt_eff} + 1'b1;
   assign stored   = ovf_eff ? lim_eff[LEN_W-1:0] : rcv[LEN_W-1:0];
   assign runt     = rcv < (CW+1)'(MIN_FRAME);

   assign wb_en    = in_frame && in_eof;
   assign wb_eor   = take ? d_status[EOR_BIT] : eor_q;
   assign miss_inc = skip;

   always_comb begin
      wb_status              = '0;
      wb_status[LEN_W-1:0]   = stored;
      wb_status[EOR_BIT]     = wb_eor;
      wb_status[CRC_BIT]     = in_crc_err;
      wb_status[RUNT_BIT]    = runt;
      wb_status[OVS_BIT]     = ovf_eff;
      wb_status[ERR_BIT]     = in_crc_err || runt || ovf_eff;
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         FS_IDLE: begin
            if (take && !in_eof)      st_d = FS_STORE;
            else if (skip && !in_eof) st_d = FS_DROP;
         end
         FS_STORE, FS_DROP: if (in_valid && in_eof) st_d = FS_IDLE;
         default: st_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FS_IDLE;
         cnt_q  <= '0;
         lim_q  <= '0;
         base_q <= '0;
         ovf_q  <= 1'b0;
         eor_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (in_frame) begin
            cnt_q <= cnt_nx;
            ovf_q <= ovf_eff;
         end
         if (take) begin
            lim_q  <= lim_new;
            base_q <= d_buf_lo;
            eor_q  <= d_status[EOR_BIT];
         end
      end
   end
endmodule

// File: rtl/rxr_ring_wb.sv
module rxr_ring_wb
   import rxr_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int MIN_FRAME = 64,
   parameter int CNT_W     = 32,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [7:0]        in_data,
   input  logic              in_crc_err,
   input  logic [MAXL_W-1:0] cfg_max_len,
   input  logic              host_we,
   input  logic [IW-1:0]     host_idx,
   input  logic [1:0]        host_word,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              buf_we,
   output logic [31:0]       buf_addr,
   output logic [7:0]        buf_data,
   output logic [IW-1:0]     cur_idx,
   output logic [CNT_W-1:0]  missed_cnt,
   output logic [1:0]        irq_status,
   input  logic [1:0]        irq_clr
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxr_ring_wb: DEPTH must be at least 2");
      end
      if (MIN_FRAME < 1 || MIN_FRAME > 8191) begin : g_bad_min
         $error("rxr_ring_wb: MIN_FRAME out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rxr_ring_wb: CNT_W must be positive");
      end
   endgenerate

   logic [31:0] d_status, d_buf_lo, wb_status;
   logic        wb_en, wb_eor, miss_inc;
   logic [1:0]  irq_set;

   rxr_desc_mem #(.DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_idx(host_idx), .host_word(host_word),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .hw_idx(cur_idx), .hw_status(d_status), .hw_buf_lo(d_buf_lo),
      .wb_en(wb_en), .wb_status(wb_status)
   );

   rxr_frame_ctl #(.MIN_FRAME(MIN_FRAME)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_data(in_data), .in_crc_err(in_crc_err), .cfg_max_len(cfg_max_len),
      .d_status(d_status), .d_buf_lo(d_buf_lo),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .wb_en(wb_en), .wb_status(wb_status), .wb_eor(wb_eor),
      .miss_inc(miss_inc)
   );

   rxr_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(wb_en), .eor(wb_eor), .idx(cur_idx)
   );

   assign irq_set = {wb_en && wb_status[ERR_BIT], wb_en && !wb_status[ERR_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         missed_cnt <= '0;
         irq_status <= '0;
      end else begin
         if (miss_inc) missed_cnt <= missed_cnt + 1'b1;
         irq_status <= (irq_status & ~irq_clr) | irq_set;
      end
   end
endmodule

// File: rtl/rxr_ring_wb_chk.sv
module rxr_ring_wb_chk #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 32,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             buf_we,
   input logic [IW-1:0]    cur_idx,
   input logic [CNT_W-1:0] missed_cnt,
   input logic [1:0]       irq_status,
   input logic [1:0]       irq_clr,
   input logic             wb_en,
   input logic [31:0]      wb_status
);
   p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_idx) < DEPTH);

   p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx != $past(cur_idx)) |-> (cur_idx == '0 || cur_idx == $past(cur_idx) + 1'b1));

   p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (missed_cnt == $past(missed_cnt)) || (missed_cnt == $past(missed_cnt) + 1'b1));

   p_write_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> in_valid);

   p_err_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && (wb_status[19] || wb_status[20] || wb_status[22])) |-> wb_status[21]);

   p_wb_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> !wb_status[31]);

   p_irq_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> (irq_status != 2'b00));

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[0] && !irq_clr[0]) |=> irq_status[0]);
endmodule

bind rxr_ring_wb rxr_ring_wb_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .buf_we(buf_we),
   .cur_idx(cur_idx), .missed_cnt(missed_cnt), .irq_status(irq_status),
   .irq_clr(irq_clr), .wb_en(wb_en), .wb_status(wb_status)
);

// File: tb/rxr_ring_wb_test.sv
`timescale 1ns/1ps
module rxr_ring_wb_test;
   localparam int DEPTH = 4;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        in_valid = 0, in_sof = 0, in_eof = 0, in_crc_err = 0;
   logic [7:0]  in_data = 0;
   logic [15:0] cfg_max_len = 16'h0800;
   logic        host_we = 0;
   logic [1:0]  host_idx = 0, host_word = 0;
   logic [31:0] host_wdata = 0, host_rdata;
   logic        buf_we;
   logic [31:0] buf_addr;
   logic [7:0]  buf_data;
   logic [1:0]  cur_idx;
   logic [31:0] missed_cnt;
   logic [1:0]  irq_status;
   logic [1:0]  irq_clr = 0;

   int total = 0, bad = 0;
   int exp_idx = 0, exp_miss = 0;
   logic [1:0] exp_irq = 0;
   logic [31:0] base [DEPTH];
   bit armed [DEPTH];

   always #5 clk = ~clk;

   rxr_ring_wb uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data), .in_crc_err(in_crc_err),
      .cfg_max_len(cfg_max_len), .host_we(host_we), .host_idx(host_idx),
      .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .cur_idx(cur_idx), .missed_cnt(missed_cnt), .irq_status(irq_status),
      .irq_clr(irq_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status(int len, int size, int maxl, bit crc, bit eor);
      int lim = (size < maxl) ? size : maxl;
      bit ovf = len > lim;
      bit runt = len < 64;
      logic [31:0] s = 32'(ovf ? lim : len);
      s[30] = eor;
      s[19] = crc;
      s[20] = runt;
      s[22] = ovf;
      s[21] = crc | runt | ovf;
      return s;
   endfunction

   task automatic host_wr(input int idx, input int word, input logic [31:0] d);
      @(negedge clk);
      host_we = 1; host_idx = 2'(idx); host_word = 2'(word); host_wdata = d;
      @(negedge clk);
      host_we = 0;
   endtask

   task automatic host_rd(input int idx, input int word, output logic [31:0] d);
      @(negedge clk);
      host_idx = 2'(idx); host_word = 2'(word);
      #1 d = host_rdata;
   endtask

   task automatic arm(input int idx, input int size);
      host_wr(idx, 0, 32'h8000_0000 | (idx == DEPTH-1 ? 32'h4000_0000 : 0) | 32'(size));
      armed[idx] = 1;
   endtask

   task automatic clr_irq(input logic [1:0] m);
      @(negedge clk); irq_clr = m;
      @(negedge clk); irq_clr = 0;
      exp_irq &= ~m;
   endtask

   // drives one frame and checks every buffer write; returns mismatch count
   task automatic send_frame(input int len, input bit crc, input bit own, input int lim,
                             input logic [31:0] b, input bit gaps, output int errs);
      errs = 0;
      for (int k = 0; k < len; k++) begin
         if (gaps && ($urandom % 8 == 0)) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_eof = 0;
            #1 if (buf_we !== 1'b0) errs++;
         end
         @(negedge clk);
         in_valid = 1; in_sof = (k == 0); in_eof = (k == len-1);
         in_data = 8'($urandom); in_crc_err = crc && (k == len-1);
         #1;
         if (own && k < lim) begin
            if (buf_we !== 1'b1 || buf_addr !== b + 32'(k) || buf_data !== in_data) errs++;
         end else if (buf_we !== 1'b0) errs++;
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; in_crc_err = 0;
   endtask

   // full frame: drive, then check status, index, miss count and interrupts
   task automatic frame(input string req, input int len, input bit crc, input int size,
                        input int maxl, input bit gaps);
      int errs, lim;
      logic [31:0] st_before, st;
      bit own = armed[exp_idx];
      bit eor = (exp_idx == DEPTH-1);
      logic [31:0] es;
      lim = (size < maxl) ? size : maxl;
      cfg_max_len = 16'(maxl);
      host_rd(exp_idx, 0, st_before);
      send_frame(len, crc, own, lim, base[exp_idx], gaps, errs);
      chk({req, " buffer writes"}, 32'(errs), 0);
      host_rd(exp_idx, 0, st);
      if (own) begin
         es = exp_status(len, size, maxl, crc, eor);
         chk({req, " status word"}, st, es);
         exp_irq |= es[21] ? 2'b10 : 2'b01;
         armed[exp_idx] = 0;
         exp_idx = eor ? 0 : (exp_idx + 1) % DEPTH;
      end else begin
         chk({req, " R8 untouched status"}, st, st_before);
         exp_miss++;
      end
      chk({req, " R7 index"}, 32'(cur_idx), 32'(exp_idx));
      chk({req, " R8 missed count"}, missed_cnt, 32'(exp_miss));
      chk({req, " R9 irq"}, 32'(irq_status), 32'(exp_irq));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      void'($urandom(32'h0005_eed1));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 index", 32'(cur_idx), 0);
      chk("R1 irq", 32'(irq_status), 0);
      chk("R1 missed", missed_cnt, 0);
      chk("R1 no write", 32'(buf_we), 0);
      rst_n = 1;

      for (int i = 0; i < DEPTH; i++) begin
         base[i] = 32'h0001_0000 * (i + 1) + 32'(i * 3);
         host_wr(i, 2, base[i]);
         host_wr(i, 1, 32'hA5A5_0000 + 32'(i));
         arm(i, 1536);
      end
      host_rd(2, 1, d);
      chk("R10 tag readback", d, 32'hA5A5_0002);
      host_rd(1, 2, d);
      chk("R10 buffer low readback", d, base[1]);

      frame("R2 R3 clean 100", 100, 0, 1536, 2048, 1);
      clr_irq(2'b01);
      chk("R9 clear", 32'(irq_status), 0);
      frame("R4 crc 80", 80, 1, 1536, 2048, 0);
      frame("R5 runt 20", 20, 0, 1536, 2048, 0);
      frame("R7 eor entry 200", 200, 0, 1536, 2048, 1);
      frame("R8 drop unarmed", 90, 0, 1536, 2048, 0);
      arm(0, 1536);
      frame("R6 max_len cut", 300, 0, 1536, 150, 0);
      arm(1, 70);
      frame("R6 capacity cut", 120, 0, 70, 2048, 1);
      frame("R5 single byte drop", 1, 0, 1536, 2048, 0);
      clr_irq(2'b11);

      for (int n = 0; n < 36; n++) begin
         int size = 64 + int'($urandom % 600);
         int maxl = ($urandom % 3 == 0) ? 64 + int'($urandom % 600) : 2048;
         int len  = 1 + int'($urandom % 800);
         bit crc  = ($urandom % 4 == 0);
         if ($urandom % 6 != 0) arm(exp_idx, size);
         if ($urandom % 5 == 0) clr_irq(2'($urandom));
         frame("R2 R3 R7 random", len, crc, size, maxl, 1);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule